// File: doc/BRIEF.md
# Set-Associative Address Translation Cache with Access Checks

This block keeps recently used page translations next to the processor so that most memory references avoid a page-table walk. A request carries a 32-bit virtual address, a write flag and a user-mode flag. When the page is cached and the access is allowed, the block returns the physical address one cycle later. When the page is not cached, it asks an external page-table walker for the mapping, stores the returned entry and then answers the original request.

Each cached mapping carries a physical page number and four attribute flags: global, supervisor-only, writable and already-dirty. Every hit is checked against the requester's mode and access type. A write to a writable page whose dirty flag is still clear goes back to the walker, so the page-table entry in memory is marked dirty exactly once. Software can drop one mapping by page number, or drop every mapping that is not global when the address space changes.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1 and `resp_valid`, `walk_req` are 0, so the first access to any page goes to the walker.
- R2: The virtual page number is `req_vaddr[31:12]`. Its low 4 bits `req_vaddr[15:12]` select one of 16 sets and its upper 16 bits `req_vaddr[31:16]` are the tag compared in the 4 ways of that set. `walk_vpn` carries the full 20-bit page number.
- R3: A request is taken in a cycle where `req_valid` and `req_ready` are both 1. A permitted hit gives `resp_valid`=1 in the next cycle with `resp_paddr` = {cached PPN, `req_vaddr[11:0]`}, `resp_fault`=0, and raises no walk.
- R4: A miss raises `walk_req` in the next cycle and holds it, with `walk_vpn` and `walk_write` steady, until `walk_ack`. The entry given with the acknowledge is installed. One cycle after the acknowledge `resp_valid`=1 with `resp_paddr` = {`walk_ppn`, page offset}. `req_ready` is 0 while the walk is open.
- R5: A user access (`req_user`=1) to a supervisor-only page, or a write to a page that is not writable, answers with `resp_fault`=1 and `resp_paddr`=0. On a hit no walk starts. On a refill the entry is installed and the same check sets `resp_fault`.
- R6: A write that hits a writable entry whose dirty flag is 0 goes to the walker as a miss with `walk_write`=1. The refilled entry is stored with dirty set, so the next write to that page hits. A read of a clean entry hits.
- R7: A refill goes into the lowest-numbered invalid way of the set. If no way is invalid it goes into the way chosen by a 3-bit tree per set: bit0=0 selects way bit1?1:0, and bit0=1 selects way bit2?3:2. A permitted hit or an install on way w sets bit0 = (w<2). For w<2 it also sets bit1 = (w==0); otherwise it sets bit2 = (w==2). Faulting hits leave the tree alone. All trees reset to 0.
- R8: `inv_valid` with `inv_vpn` clears the entry holding that page, even if it is global. Other pages stay cached.
- R9: `flush_ctx` clears every entry whose global flag is 0 and keeps the global entries.
- R10: A dirty refill reuses the way of the clean entry it replaces, so a page never sits in two ways and the other ways of the set keep their pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle; a request is taken |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| resp_valid | output | 1 | Response valid for one cycle |
| resp_paddr | output | 32 | Physical address (0 on fault) |
| resp_fault | output | 1 | Protection fault |
| walk_req | output | 1 | Refill request to the walker |
| walk_vpn | output | 20 | Page number to walk |
| walk_write | output | 1 | Walk is for a write (mark dirty) |
| walk_ack | input | 1 | Walker returns the entry |
| walk_ppn | input | 20 | Returned physical page number |
| walk_global | input | 1 | Returned global flag |
| walk_super | input | 1 | Returned supervisor-only flag |
| walk_writable | input | 1 | Returned writable flag |
| walk_dirty | input | 1 | Returned dirty flag |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Page number to invalidate |
| flush_ctx | input | 1 | Drop all non-global entries |

## Verification
On every cycle the assertions check the following: no page matches in more than one way, a walk request stays steady until acknowledged, a permitted hit answers next cycle without a walk, a faulting hit never starts a walk, a clean-write hit always walks, and a context flush leaves no non-global entry while keeping the global ones. The choice of victim way, the exact physical addresses, the survival of a global page after an invalidate of a neighbour, and the end-to-end effect of dirty upgrades can only be shown by the bench. It drives full-set sweeps and a long pseudo-random access stream against its own arithmetic model of the sets and trees.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int TLB_WAYS = 4;
  localparam int WAY_W    = 2;

  typedef enum logic {ST_IDLE, ST_WALK} tlb_state_e;

  // tree bits: [0] root, [1] left pair, [2] right pair; bits point at victim
  function automatic logic [2:0] plru_touch(input logic [2:0] s, input logic [WAY_W-1:0] w);
    logic [2:0] n;
    n = s;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  function automatic logic [WAY_W-1:0] plru_pick(input logic [2:0] s);
    return s[0] ? {1'b1, s[2]} : {1'b0, s[1]};
  endfunction
endpackage

// File: rtl/tlb_repl.sv
module tlb_repl
  import tlb_pkg::*;
#(
  parameter int SET_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                touch_en,
  input  logic [SET_BITS-1:0] touch_set,
  input  logic [WAY_W-1:0]    touch_way,
  input  logic [SET_BITS-1:0] pick_set,
  output logic [WAY_W-1:0]    pick_way
);
  localparam int SETS = 1 << SET_BITS;

  logic [2:0] tree_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= 3'b000;
    end else if (touch_en) begin
      tree_q[touch_set] <= plru_touch(tree_q[touch_set], touch_way);
    end
  end

  assign pick_way = plru_pick(tree_q[pick_set]);
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int SET_BITS = 4,
  parameter int TAG_W    = 16,
  parameter int PPN_W    = 20
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SET_BITS-1:0]               rd_set,
  output logic [TLB_WAYS-1:0]               rd_vld,
  output logic [TLB_WAYS-1:0]               rd_glb,
  output logic [TLB_WAYS-1:0]               rd_sup,
  output logic [TLB_WAYS-1:0]               rd_wrt,
  output logic [TLB_WAYS-1:0]               rd_dty,
  output logic [TLB_WAYS-1:0][TAG_W-1:0]    rd_tag,
  output logic [TLB_WAYS-1:0][PPN_W-1:0]    rd_ppn,
  input  logic                              wr_en,
  input  logic [SET_BITS-1:0]               wr_set,
  input  logic [WAY_W-1:0]                  wr_way,
  input  logic [TAG_W-1:0]                  wr_tag,
  input  logic [PPN_W-1:0]                  wr_ppn,
  input  logic                              wr_glb,
  input  logic                              wr_sup,
  input  logic                              wr_wrt,
  input  logic                              wr_dty,
  input  logic                              inv_en,
  input  logic [SET_BITS-1:0]               inv_set,
  input  logic [TAG_W-1:0]                  inv_tag,
  input  logic                              flush
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int CELLS = SETS * TLB_WAYS;

  logic             vld_q [SETS][TLB_WAYS];
  logic             glb_q [SETS][TLB_WAYS];
  logic             sup_q [SETS][TLB_WAYS];
  logic             wrt_q [SETS][TLB_WAYS];
  logic             dty_q [SETS][TLB_WAYS];
  logic [TAG_W-1:0] tag_q [SETS][TLB_WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][TLB_WAYS];

  // global / non-global occupancy, brought out for the checks below
  logic [CELLS-1:0] live_glb;
  logic [CELLS-1:0] live_loc;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < TLB_WAYS; w++) begin : g_way
      assign live_glb[s*TLB_WAYS+w] = vld_q[s][w] &  glb_q[s][w];
      assign live_loc[s*TLB_WAYS+w] = vld_q[s][w] & ~glb_q[s][w];
    end
  end

  always_comb begin
    for (int w = 0; w < TLB_WAYS; w++) begin
      rd_vld[w] = vld_q[rd_set][w];
      rd_glb[w] = glb_q[rd_set][w];
      rd_sup[w] = sup_q[rd_set][w];
      rd_wrt[w] = wrt_q[rd_set][w];
      rd_dty[w] = dty_q[rd_set][w];
      rd_tag[w] = tag_q[rd_set][w];
      rd_ppn[w] = ppn_q[rd_set][w];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      glb_q[wr_set][wr_way] <= wr_glb;
      sup_q[wr_set][wr_way] <= wr_sup;
      wrt_q[wr_set][wr_way] <= wr_wrt;
      dty_q[wr_set][wr_way] <= wr_dty;
      tag_q[wr_set][wr_way] <= wr_tag;
      ppn_q[wr_set][wr_way] <= wr_ppn;
    end
  end

  // an install in the same cycle is seen by invalidate and flush
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < TLB_WAYS; w++) vld_q[s][w] <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_set][wr_way] <= 1'b1;
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < TLB_WAYS; w++) begin
          logic fresh;
          logic eg;
          logic [TAG_W-1:0] et;
          fresh = wr_en && (wr_set == SET_BITS'(s)) && (wr_way == WAY_W'(w));
          eg = fresh ? wr_glb : glb_q[s][w];
          et = fresh ? wr_tag : tag_q[s][w];
          if (flush && !eg) vld_q[s][w] <= 1'b0;
          if (inv_en && (inv_set == SET_BITS'(s)) && (et == inv_tag)) vld_q[s][w] <= 1'b0;
        end
      end
    end
  end

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (live_loc == '0));

  assert_flush_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !wr_en && !inv_en) |=> $stable(live_glb));
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int TAG_W = 16
) (
  input  logic [TLB_WAYS-1:0]            vld,
  input  logic [TLB_WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]               look_tag,
  output logic [TLB_WAYS-1:0]            hit_vec,
  output logic                           hit,
  output logic [WAY_W-1:0]               hit_way,
  output logic                           free_ok,
  output logic [WAY_W-1:0]               free_way
);
  for (genvar w = 0; w < TLB_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld[w] && (tags[w] == look_tag);
  end

  assign hit     = |hit_vec;
  assign free_ok = ~&vld;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = TLB_WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way  = WAY_W'(w);
      if (!vld[w])    free_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int OFF_W    = 12,
  parameter int SET_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic                  req_write,
  input  logic                  req_user,
  output logic                  resp_valid,
  output logic [PA_W-1:0]       resp_paddr,
  output logic                  resp_fault,
  output logic                  walk_req,
  output logic [VA_W-OFF_W-1:0] walk_vpn,
  output logic                  walk_write,
  input  logic                  walk_ack,
  input  logic [PA_W-OFF_W-1:0] walk_ppn,
  input  logic                  walk_global,
  input  logic                  walk_super,
  input  logic                  walk_writable,
  input  logic                  walk_dirty,
  input  logic                  inv_valid,
  input  logic [VA_W-OFF_W-1:0] inv_vpn,
  input  logic                  flush_ctx
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int TAG_W = VPN_W - SET_BITS;

  function automatic logic [SET_BITS-1:0] vpn_set(input logic [VPN_W-1:0] v);
    return v[SET_BITS-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] vpn_tag(input logic [VPN_W-1:0] v);
    return v[VPN_W-1:SET_BITS];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PPN_W-1:0] p, input logic [OFF_W-1:0] o);
    return {p, o};
  endfunction

  function automatic logic denied(input logic user, input logic wr, input logic sup, input logic wrt);
    return (user && sup) || (wr && !wrt);
  endfunction

  tlb_state_e state_q;

  logic [VPN_W-1:0] pend_vpn;
  logic [OFF_W-1:0] pend_off;
  logic             pend_write;
  logic             pend_user;
  logic [WAY_W-1:0] pend_way;

  logic [VPN_W-1:0]    rq_vpn;
  logic [OFF_W-1:0]    rq_off;
  logic [SET_BITS-1:0] rq_set;
  logic [TAG_W-1:0]    rq_tag;

  assign rq_vpn = req_vaddr[VA_W-1:OFF_W];
  assign rq_off = req_vaddr[OFF_W-1:0];
  assign rq_set = vpn_set(rq_vpn);
  assign rq_tag = vpn_tag(rq_vpn);

  logic [TLB_WAYS-1:0]            rd_vld, rd_glb, rd_sup, rd_wrt, rd_dty;
  logic [TLB_WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [TLB_WAYS-1:0][PPN_W-1:0] rd_ppn;

  logic [TLB_WAYS-1:0] hit_vec;
  logic                hit;
  logic [WAY_W-1:0]    hit_way;
  logic                free_ok;
  logic [WAY_W-1:0]    free_way;
  logic [WAY_W-1:0]    tree_way;

  // named internal events
  logic ev_accept, ev_hit, ev_fault, ev_walk, ev_install;
  logic perm_bad, need_dirty, inst_bad;
  logic [WAY_W-1:0] victim;
  logic [PPN_W-1:0] h_ppn;
  logic             h_sup, h_wrt, h_dty;

  assign h_ppn = rd_ppn[hit_way];
  assign h_sup = rd_sup[hit_way];
  assign h_wrt = rd_wrt[hit_way];
  assign h_dty = rd_dty[hit_way];

  assign req_ready  = (state_q == ST_IDLE);
  assign ev_accept  = req_valid && req_ready;
  assign perm_bad   = hit && denied(req_user, req_write, h_sup, h_wrt);
  assign need_dirty = hit && !perm_bad && req_write && !h_dty;
  assign ev_hit     = ev_accept && hit && !perm_bad && !need_dirty;
  assign ev_fault   = ev_accept && perm_bad;
  assign ev_walk    = ev_accept && (!hit || need_dirty);
  assign ev_install = (state_q == ST_WALK) && walk_ack;
  assign inst_bad   = denied(pend_user, pend_write, walk_super, walk_writable);
  assign victim     = hit ? hit_way : (free_ok ? free_way : tree_way);

  tlb_store #(.SET_BITS(SET_BITS), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_set  (rq_set),
    .rd_vld  (rd_vld),
    .rd_glb  (rd_glb),
    .rd_sup  (rd_sup),
    .rd_wrt  (rd_wrt),
    .rd_dty  (rd_dty),
    .rd_tag  (rd_tag),
    .rd_ppn  (rd_ppn),
    .wr_en   (ev_install),
    .wr_set  (vpn_set(pend_vpn)),
    .wr_way  (pend_way),
    .wr_tag  (vpn_tag(pend_vpn)),
    .wr_ppn  (walk_ppn),
    .wr_glb  (walk_global),
    .wr_sup  (walk_super),
    .wr_wrt  (walk_writable),
    .wr_dty  (walk_dirty | pend_write),
    .inv_en  (inv_valid),
    .inv_set (vpn_set(inv_vpn)),
    .inv_tag (vpn_tag(inv_vpn)),
    .flush   (flush_ctx)
  );

  tlb_match #(.TAG_W(TAG_W)) u_match (
    .vld      (rd_vld),
    .tags     (rd_tag),
    .look_tag (rq_tag),
    .hit_vec  (hit_vec),
    .hit      (hit),
    .hit_way  (hit_way),
    .free_ok  (free_ok),
    .free_way (free_way)
  );

  tlb_repl #(.SET_BITS(SET_BITS)) u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (ev_hit | ev_install),
    .touch_set (ev_install ? vpn_set(pend_vpn) : rq_set),
    .touch_way (ev_install ? pend_way : hit_way),
    .pick_set  (rq_set),
    .pick_way  (tree_way)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      walk_req   <= 1'b0;
      resp_valid <= 1'b0;
      resp_paddr <= '0;
      resp_fault <= 1'b0;
      pend_vpn   <= '0;
      pend_off   <= '0;
      pend_write <= 1'b0;
      pend_user  <= 1'b0;
      pend_way   <= '0;
    end else begin
      resp_valid <= ev_hit | ev_fault | ev_install;
      if (ev_hit) begin
        resp_paddr <= join_pa(h_ppn, rq_off);
        resp_fault <= 1'b0;
      end
      if (ev_fault) begin
        resp_paddr <= '0;
        resp_fault <= 1'b1;
      end
      if (ev_walk) begin
        state_q    <= ST_WALK;
        walk_req   <= 1'b1;
        pend_vpn   <= rq_vpn;
        pend_off   <= rq_off;
        pend_write <= req_write;
        pend_user  <= req_user;
        pend_way   <= victim;
      end
      if (ev_install) begin
        state_q    <= ST_IDLE;
        walk_req   <= 1'b0;
        resp_paddr <= inst_bad ? '0 : join_pa(walk_ppn, pend_off);
        resp_fault <= inst_bad;
      end
    end
  end

  assign walk_vpn   = pend_vpn;
  assign walk_write = pend_write;

  assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_walk_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_ack) |=> (walk_req && $stable(walk_vpn) && $stable(walk_write)));

  assert_hit_answers_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |=> (resp_valid && !resp_fault && !walk_req));

  assert_fault_no_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> (resp_valid && resp_fault && !walk_req && resp_paddr == '0));

  assert_clean_write_walks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && hit && !perm_bad && req_write && !h_dty) |=> (walk_req && walk_write));

  assert_busy_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !req_ready);
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        resp_valid;
  logic [31:0] resp_paddr;
  logic        resp_fault;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic        walk_write;
  logic        walk_ack = 1'b0;
  logic [19:0] walk_ppn = '0;
  logic        walk_global = 1'b0;
  logic        walk_super = 1'b0;
  logic        walk_writable = 1'b0;
  logic        walk_dirty = 1'b0;
  logic        inv_valid = 1'b0;
  logic [19:0] inv_vpn = '0;
  logic        flush_ctx = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_user(req_user),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_write(walk_write),
    .walk_ack(walk_ack), .walk_ppn(walk_ppn), .walk_global(walk_global),
    .walk_super(walk_super), .walk_writable(walk_writable), .walk_dirty(walk_dirty),
    .inv_valid(inv_valid), .inv_vpn(inv_vpn), .flush_ctx(flush_ctx)
  );

  // page table seen by the bench walker, keyed on the tag
  function automatic bit pt_sup(input logic [15:0] t); return t[1:0] == 2'd3; endfunction
  function automatic bit pt_wrt(input logic [15:0] t); return t[1:0] != 2'd2; endfunction
  function automatic bit pt_glb(input logic [15:0] t); return t[2]; endfunction
  function automatic logic [19:0] pt_ppn(input logic [19:0] v);
    return 20'((v * 20'd13) + 20'd5);
  endfunction

  // reference state
  bit          m_vld [16][4];
  logic [15:0] m_tag [16][4];
  bit          m_glb [16][4];
  bit          m_sup [16][4];
  bit          m_wrt [16][4];
  bit          m_dty [16][4];
  logic [2:0]  m_tree [16];

  function automatic int tree_victim(input logic [2:0] p);
    if (p[0] == 1'b0) return p[1] ? 1 : 0;
    return p[2] ? 3 : 2;
  endfunction

  function automatic logic [2:0] tree_after(input logic [2:0] p, input int w);
    logic [2:0] q;
    q = p;
    q[0] = (w < 2);
    if (w < 2) q[1] = (w == 0);
    else       q[2] = (w == 2);
    return q;
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] tag, input logic [3:0] set, input logic [11:0] off,
                        input bit wr, input bit usr, input string lbl);
    int h;
    int way;
    bit bad;
    bit do_walk;
    logic [19:0] vpn;
    h = -1;
    vpn = {tag, set};
    for (int w = 0; w < 4; w++) if (m_vld[set][w] && m_tag[set][w] == tag) h = w;
    do_walk = 1'b0;
    bad = 1'b0;
    if (h >= 0) begin
      bad = (usr && m_sup[set][h]) || (wr && !m_wrt[set][h]);
      if (!bad && wr && !m_dty[set][h]) do_walk = 1'b1;
    end else do_walk = 1'b1;

    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {tag, set, off}; req_write = wr; req_user = usr;
    @(negedge clk);
    req_valid = 1'b0;

    if (!do_walk) begin
      if (bad) begin
        check("R5", "fault resp_valid", 32'(resp_valid), 32'd1);
        check("R5", "fault flag", 32'(resp_fault), 32'd1);
        check("R5", "fault paddr", resp_paddr, 32'd0);
        check("R5", "no walk on fault", 32'(walk_req), 32'd0);
      end else begin
        check("R3", "hit resp_valid", 32'(resp_valid), 32'd1);
        check("R3", "hit paddr", resp_paddr, {pt_ppn(vpn), off});
        check("R3", "hit fault", 32'(resp_fault), 32'd0);
        check("R3", "no walk on hit", 32'(walk_req), 32'd0);
        m_tree[set] = tree_after(m_tree[set], h);
      end
      if (walk_req) begin
        walk_ack = 1'b1; @(negedge clk); walk_ack = 1'b0;
      end
    end else begin
      if (h >= 0) way = h;
      else begin
        way = -1;
        for (int w = 3; w >= 0; w--) if (!m_vld[set][w]) way = w;
        if (way < 0) way = tree_victim(m_tree[set]);
      end
      check(lbl, "walk_req", 32'(walk_req), 32'd1);
      check("R2", "walk_vpn", 32'(walk_vpn), 32'(vpn));
      check(lbl, "walk_write", 32'(walk_write), 32'(wr));
      check("R4", "not ready in walk", 32'(req_ready), 32'd0);
      walk_ack = 1'b1; walk_ppn = pt_ppn(vpn);
      walk_global = pt_glb(tag); walk_super = pt_sup(tag);
      walk_writable = pt_wrt(tag); walk_dirty = wr;
      @(negedge clk);
      walk_ack = 1'b0;
      bad = (usr && pt_sup(tag)) || (wr && !pt_wrt(tag));
      check(lbl, "refill resp_valid", 32'(resp_valid), 32'd1);
      check(bad ? "R5" : lbl, "refill fault", 32'(resp_fault), 32'(bad));
      check(lbl, "refill paddr", resp_paddr, bad ? 32'd0 : {pt_ppn(vpn), off});
      m_vld[set][way] = 1'b1; m_tag[set][way] = tag;
      m_glb[set][way] = pt_glb(tag); m_sup[set][way] = pt_sup(tag);
      m_wrt[set][way] = pt_wrt(tag); m_dty[set][way] = wr;
      m_tree[set] = tree_after(m_tree[set], way);
    end
  endtask

  task automatic invalidate(input logic [15:0] tag, input logic [3:0] set);
    @(negedge clk);
    inv_valid = 1'b1; inv_vpn = {tag, set};
    @(negedge clk);
    inv_valid = 1'b0;
    for (int w = 0; w < 4; w++) if (m_vld[set][w] && m_tag[set][w] == tag) m_vld[set][w] = 1'b0;
  endtask

  task automatic flush();
    @(negedge clk);
    flush_ctx = 1'b1;
    @(negedge clk);
    flush_ctx = 1'b0;
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 4; w++) if (!m_glb[s][w]) m_vld[s][w] = 1'b0;
  endtask

  initial begin
    logic [15:0] lfsr;
    for (int s = 0; s < 16; s++) begin
      m_tree[s] = 3'b000;
      for (int w = 0; w < 4; w++) begin
        m_vld[s][w] = 1'b0; m_tag[s][w] = '0; m_glb[s][w] = 1'b0;
        m_sup[s][w] = 1'b0; m_wrt[s][w] = 1'b0; m_dty[s][w] = 1'b0;
      end
    end
    repeat (3) @(negedge clk);
    check("R1", "reset resp_valid", 32'(resp_valid), 32'd0);
    check("R1", "reset walk_req", 32'(walk_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready after reset", 32'(req_ready), 32'd1);
    access(16'd0, 4'd0, 12'h123, 1'b0, 1'b0, "R1");

    // fill every way of every set, then read all back
    for (int s = 0; s < 16; s++)
      for (int t = 0; t < 4; t++) access(16'(t), 4'(s), 12'(s * 37 + t), 1'b0, 1'b0, "R4");
    for (int s = 0; s < 16; s++)
      for (int t = 0; t < 4; t++) access(16'(t), 4'(s), 12'(4095 - s - t), 1'b0, 1'b0, "R3");

    // replacement once the sets are full
    for (int s = 0; s < 16; s++)
      for (int t = 8; t < 13; t++) access(16'(t), 4'(s), 12'h0A0, 1'b0, 1'b0, "R7");
    for (int s = 0; s < 16; s++)
      for (int t = 0; t < 4; t++) access(16'(t + 8), 4'(s), 12'h0B0, 1'b0, 1'b0, "R7");

    // protection
    access(16'd3, 4'd5, 12'h010, 1'b0, 1'b0, "R5");
    access(16'd3, 4'd5, 12'h010, 1'b0, 1'b1, "R5");
    access(16'd2, 4'd5, 12'h020, 1'b0, 1'b0, "R5");
    access(16'd2, 4'd5, 12'h020, 1'b1, 1'b0, "R5");
    access(16'd7, 4'd5, 12'h030, 1'b0, 1'b1, "R5");

    // dirty upgrade keeps the same way
    access(16'd1, 4'd7, 12'h040, 1'b0, 1'b0, "R6");
    access(16'd1, 4'd7, 12'h044, 1'b1, 1'b0, "R6");
    access(16'd1, 4'd7, 12'h048, 1'b1, 1'b0, "R6");
    for (int t = 20; t < 23; t++) access(16'(t), 4'd7, 12'h050, 1'b0, 1'b0, "R10");
    access(16'd1, 4'd7, 12'h04C, 1'b1, 1'b0, "R10");

    // invalidate a global page, neighbour stays
    access(16'd4, 4'd3, 12'h100, 1'b0, 1'b0, "R8");
    access(16'd5, 4'd3, 12'h104, 1'b0, 1'b0, "R8");
    invalidate(16'd4, 4'd3);
    access(16'd5, 4'd3, 12'h108, 1'b0, 1'b0, "R8");
    access(16'd4, 4'd3, 12'h10C, 1'b0, 1'b0, "R8");

    // context flush keeps globals
    access(16'd4, 4'd9, 12'h200, 1'b0, 1'b0, "R9");
    access(16'd1, 4'd9, 12'h204, 1'b0, 1'b0, "R9");
    flush();
    access(16'd4, 4'd9, 12'h208, 1'b0, 1'b0, "R9");
    access(16'd1, 4'd9, 12'h20C, 1'b0, 1'b0, "R9");

    // pseudo-random stream over a small tag space
    lfsr = 16'hACE1;
    for (int i = 0; i < 2500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[15:10] == 6'd0) flush();
      else if (lfsr[15:11] == 5'd1) invalidate({13'd0, lfsr[2:0]}, lfsr[6:3]);
      else access({13'd0, lfsr[2:0]}, lfsr[6:3], {lfsr[11:7], lfsr[6:0]}, lfsr[8], lfsr[9], "R7");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule